// File: doc/BRIEF.md
# Thermal Throttle and Trip Controller

This block watches a stream of digitized die temperatures together with the processor's power-state code. It drives an active-low hot indicator, a sticky catastrophic-trip output, a throttle enable and a clock-gate pattern. A pulse interrupt can be raised when the hot indicator asserts, when it releases, or on both edges. A small configuration register, written through a plain write strobe, holds the automatic-throttle enable, a software force-throttle bit, the two edge interrupt enables and a 3-bit duty code.

Temperature samples arrive on a valid/ready interface. The block never applies back-pressure: `temp_ready` is held high, and any cycle with `temp_valid` high transfers a sample, with no limit on how many arrive back to back. The hot indicator has hysteresis. It cannot newly assert while the core clocks are stopped, but once asserted it holds through a stopped-clock state. The trip output depends on temperature alone. It ignores configuration and power state, issues no transaction of any kind, and is cleared only by reset.

Top module: `thermal_guard`

## Requirements
- R1: `hot_irq` pulses high for exactly one cycle in the cycle in which `hot_n` falls if the rise enable (cfg bit 2) is set, and in the cycle in which `hot_n` rises if the fall enable (cfg bit 3) is set. At all other times it stays low.
- R2: While `pstate` is 1 (stop-grant), 2 (sleep) or 3 (deep sleep), `hot_n` does not go low, whatever the temperature. Codes 0 and 4 to 7 count as running.
- R3: If `hot_n` is already low when a stopped-clock state begins, it stays low for the whole stopped period. It releases only after `pstate` returns to a running code and the latched temperature is below the release point.
- R4: A sample is latched on each cycle with `temp_valid` high. Two clock edges after the sample is taken, `hot_n` goes low if the sample is 100 °C or more, and it goes high again only for a sample of 97 °C or less (2 °C hysteresis).
- R5: `trip` goes high one edge after a latched sample of 125 °C or more, regardless of configuration or `pstate`, and stays high until reset.
- R6: `throttle_on` equals the force bit (cfg bit 1) OR the auto enable (cfg bit 0) AND the hot state. With auto disabled and force clear there is no throttling, even above 100 °C.
- R7: While `throttle_on` is high, `clk_gate` is high in exactly `duty` cycles (cfg bits 6:4) of every 8 consecutive cycles. A duty code of 0 gates no cycles. `clk_gate` is low whenever `throttle_on` is low.
- R8: After reset, `hot_n`=1, `trip`=0, `hot_irq`=0 and `throttle_on`=0, and the configuration holds only the auto enable (value 7'h01).
- R9: `temp_ready` is always high, so no sample is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_valid | input | 1 | Temperature sample valid |
| temp_ready | output | 1 | Always high; the block accepts every sample |
| temp_c | input | 8 | Die temperature, unsigned °C |
| pstate | input | 3 | Power state: 0 run, 1 stop-grant, 2 sleep, 3 deep sleep, 4-7 run |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | {duty[2:0], fall_en, rise_en, force, auto_en} |
| hot_n | output | 1 | Active-low hot indicator |
| trip | output | 1 | Latched catastrophic trip |
| hot_irq | output | 1 | One-cycle interrupt pulse on enabled hot edges |
| throttle_on | output | 1 | Clock-modulation enable |
| clk_gate | output | 1 | Per-cycle gate pattern (high = cycle gated) |

## Verification
Random temperatures are clustered around the 97-100 °C band, so the bench repeatedly crosses the assert and release thresholds. The random power state sometimes lands on a stopped-clock code while the temperature is hot, and this separates the suppression rule from the holding rule. Random configuration writes change the edge enables and the duty code in the middle of a run, which exposes any mix-up between the two interrupt edges or any error in the count of gated cycles. Directed sequences then force throttling with auto disabled, hold a sample at 99 °C to test the hysteresis, and drive 125 °C while asleep with all modes off. A final reset checks that the trip latch is cleared.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
  localparam int DUTY_W = 3;

  typedef struct packed {
    logic [DUTY_W-1:0] duty;
    logic              fall_en;
    logic              rise_en;
    logic              force_on;
    logic              auto_en;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  localparam logic [2:0] PS_STOP_GRANT = 3'd1;
  localparam logic [2:0] PS_SLEEP      = 3'd2;
  localparam logic [2:0] PS_DEEP_SLEEP = 3'd3;

  function automatic logic is_stopped(input logic [2:0] ps);
    return (ps == PS_STOP_GRANT) || (ps == PS_SLEEP) || (ps == PS_DEEP_SLEEP);
  endfunction
endpackage

// File: rtl/tg_cfg_reg.sv
module tg_cfg_reg
  import thermal_guard_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_VAL = 7'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg <= cfg_t'(RESET_VAL);
    else if (we) cfg <= cfg_t'(wdata);
  end
endmodule

// File: rtl/tg_hot_tracker.sv
module tg_hot_tracker
  import thermal_guard_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int HOT_C  = 100,
  parameter int HYST_C = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_q,
  input  logic [2:0]        pstate,
  input  logic              rise_en,
  input  logic              fall_en,
  output logic              hot_q,
  output logic              irq_q
);
  localparam logic [TEMP_W-1:0] ON_T  = TEMP_W'(HOT_C);
  localparam logic [TEMP_W-1:0] REL_T = TEMP_W'(HOT_C - HYST_C);

  logic stopped, hot_d;
  assign stopped = is_stopped(pstate);

  always_comb begin
    if (stopped)    hot_d = hot_q;
    else if (hot_q) hot_d = (temp_q >= REL_T);
    else            hot_d = (temp_q >= ON_T);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      hot_q <= hot_d;
      irq_q <= (hot_d & ~hot_q & rise_en) | (~hot_d & hot_q & fall_en);
    end
  end

  a_r2_no_new_hot_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hot_q) |-> !$past(stopped));
  a_r3_hold_while_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_q && stopped) |=> hot_q);
  a_r4_release_below_band: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hot_q) |-> ($past(temp_q) < REL_T));
  a_r1_irq_on_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (hot_q != $past(hot_q)));
endmodule

// File: rtl/tg_trip_latch.sv
module tg_trip_latch #(
  parameter int TEMP_W = 8,
  parameter int TRIP_C = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_q,
  output logic              trip_q
);
  localparam logic [TEMP_W-1:0] TRIP_T = TEMP_W'(TRIP_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                trip_q <= 1'b0;
    else if (temp_q >= TRIP_T) trip_q <= 1'b1;
  end

  a_r5_trip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |=> trip_q);
  a_r5_trip_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> ($past(temp_q) >= TRIP_T));
endmodule

// File: rtl/tg_duty_mod.sv
module tg_duty_mod
  import thermal_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [DUTY_W-1:0] duty,
  output logic              gate
);
  logic [DUTY_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign gate = active && (cnt_q < duty);

  a_r7_gate_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !gate);
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thermal_guard_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int HOT_C  = 100,
  parameter int HYST_C = 2,
  parameter int TRIP_C = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              temp_valid,
  output logic              temp_ready,
  input  logic [TEMP_W-1:0] temp_c,
  input  logic [2:0]        pstate,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              hot_n,
  output logic              trip,
  output logic              hot_irq,
  output logic              throttle_on,
  output logic              clk_gate
);
  cfg_t              cfg;
  logic [TEMP_W-1:0] temp_q;
  logic              hot_q;

  assign temp_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       temp_q <= '0;
    else if (temp_valid & temp_ready) temp_q <= temp_c;
  end

  tg_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
  );

  tg_hot_tracker #(.TEMP_W(TEMP_W), .HOT_C(HOT_C), .HYST_C(HYST_C)) u_hot (
    .clk(clk), .rst_n(rst_n), .temp_q(temp_q), .pstate(pstate),
    .rise_en(cfg.rise_en), .fall_en(cfg.fall_en),
    .hot_q(hot_q), .irq_q(hot_irq)
  );

  tg_trip_latch #(.TEMP_W(TEMP_W), .TRIP_C(TRIP_C)) u_trip (
    .clk(clk), .rst_n(rst_n), .temp_q(temp_q), .trip_q(trip)
  );

  assign hot_n       = ~hot_q;
  assign throttle_on = cfg.force_on | (cfg.auto_en & hot_q);

  tg_duty_mod u_mod (
    .clk(clk), .rst_n(rst_n), .active(throttle_on), .duty(cfg.duty), .gate(clk_gate)
  );

  a_r9_always_ready: assert property (@(posedge clk) disable iff (!rst_n) temp_ready);
endmodule

// File: tb/thermal_guard_test.sv
module thermal_guard_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       temp_valid = 1'b0;
  logic       temp_ready;
  logic [7:0] temp_c = 8'd0;
  logic [2:0] pstate = 3'd0;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_wdata = 7'd0;
  logic       hot_n, trip, hot_irq, throttle_on, clk_gate;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model state
  logic [7:0] m_temp;
  logic       m_hot, m_trip, m_irq;
  logic [6:0] m_cfg;
  logic [2:0] m_cnt;

  always #2 clk = ~clk;

  thermal_guard uut (
    .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_ready(temp_ready),
    .temp_c(temp_c), .pstate(pstate), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .hot_n(hot_n), .trip(trip), .hot_irq(hot_irq), .throttle_on(throttle_on),
    .clk_gate(clk_gate)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  function automatic logic f_stopped(input logic [2:0] ps);
    return ps == 3'd1 || ps == 3'd2 || ps == 3'd3;
  endfunction

  function automatic logic f_next_hot(input logic hot, input logic [7:0] t, input logic [2:0] ps);
    if (f_stopped(ps)) return hot;
    if (hot) return t > 8'd97;
    return t >= 8'd100;
  endfunction

  function automatic logic f_throttle(input logic [6:0] c, input logic hot);
    return c[1] | (c[0] & hot);
  endfunction

  task automatic compare_all();
    logic thr;
    thr = f_throttle(m_cfg, m_hot);
    check(hot_n, ~m_hot, "R4 hot_n");
    check(trip, m_trip, "R5 trip");
    check(hot_irq, m_irq, "R1 hot_irq");
    check(throttle_on, thr, "R6 throttle_on");
    check(clk_gate, thr && (m_cnt < m_cfg[6:4]), "R7 clk_gate");
    check(temp_ready, 1'b1, "R9 temp_ready");
  endtask

  // called at a negedge: drive, take one posedge, update model, compare at next negedge
  task automatic tick(input logic v, input logic [7:0] t, input logic [2:0] ps,
                      input logic we, input logic [6:0] wd);
    logic nh;
    temp_valid = v; temp_c = t; pstate = ps; cfg_we = we; cfg_wdata = wd;
    @(posedge clk);
    nh     = f_next_hot(m_hot, m_temp, ps);
    m_irq  = (nh & ~m_hot & m_cfg[2]) | (~nh & m_hot & m_cfg[3]);
    m_trip = m_trip | (m_temp >= 8'd125);
    m_hot  = nh;
    if (v) m_temp = t;
    if (we) m_cfg = wd;
    m_cnt  = m_cnt + 3'd1;
    @(negedge clk);
    temp_valid = 1'b0; cfg_we = 1'b0;
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; temp_valid = 1'b0; cfg_we = 1'b0; pstate = 3'd0;
    repeat (3) @(negedge clk);
    m_temp = 8'd0; m_hot = 1'b0; m_trip = 1'b0; m_irq = 1'b0;
    m_cfg = 7'h01; m_cnt = 3'd0;
    rst_n = 1'b1;
    // R8: reset state
    check(hot_n, 1'b1, "R8 hot_n after reset");
    check(trip, 1'b0, "R8 trip after reset");
    check(hot_irq, 1'b0, "R8 hot_irq after reset");
    check(throttle_on, 1'b0, "R8 throttle_on after reset");
  endtask

  task automatic hold(input int n, input logic [7:0] t, input logic [2:0] ps);
    for (int i = 0; i < n; i++) tick(1'b0, t, ps, 1'b0, 7'd0);
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int gated;
    logic [7:0] rt;
    logic [2:0] rps;
    void'($urandom(32'd20240611));
    do_reset();

    // R1/R4: both irq enables, duty 3
    tick(1'b0, 8'd0, 3'd0, 1'b1, {3'd3, 1'b1, 1'b1, 1'b0, 1'b1});
    tick(1'b1, 8'd100, 3'd0, 1'b0, 7'd0);
    tick(1'b0, 8'd0, 3'd0, 1'b0, 7'd0);
    check(hot_n, 1'b0, "R4 assert at 100");
    check(hot_irq, 1'b1, "R1 rise pulse");
    tick(1'b0, 8'd0, 3'd0, 1'b0, 7'd0);
    check(hot_irq, 1'b0, "R1 pulse lasts one cycle");
    // R7: count gated cycles in 8
    gated = 0;
    for (int i = 0; i < 8; i++) begin
      tick(1'b0, 8'd0, 3'd0, 1'b0, 7'd0);
      gated += int'(clk_gate);
    end
    check(gated == 3, 1'b1, "R7 three of eight gated");
    // R4 hysteresis: 99 keeps hot
    tick(1'b1, 8'd99, 3'd0, 1'b0, 7'd0);
    hold(3, 8'd0, 3'd0);
    check(hot_n, 1'b0, "R4 hold at 99");
    // R3: enter sleep while hot, cool down
    tick(1'b1, 8'd50, 3'd2, 1'b0, 7'd0);
    hold(5, 8'd0, 3'd2);
    check(hot_n, 1'b0, "R3 held in sleep");
    tick(1'b0, 8'd0, 3'd0, 1'b0, 7'd0);
    check(hot_n, 1'b1, "R3 release after exit");
    check(hot_irq, 1'b1, "R1 fall pulse");
    // R2: hot sample while in deep sleep
    tick(1'b1, 8'd115, 3'd3, 1'b0, 7'd0);
    hold(4, 8'd0, 3'd1);
    check(hot_n, 1'b1, "R2 no assert in stop states");
    tick(1'b0, 8'd0, 3'd5, 1'b0, 7'd0);
    check(hot_n, 1'b0, "R2 asserts once running");
    // R6: auto off, no throttling though hot
    tick(1'b0, 8'd0, 3'd0, 1'b1, 7'h30);
    check(throttle_on, 1'b0, "R6 auto off no throttle");
    // R6: force throttle while cool
    tick(1'b1, 8'd20, 3'd0, 1'b1, 7'h72);
    hold(2, 8'd0, 3'd0);
    check(throttle_on, 1'b1, "R6 force throttle");
    // R7: duty 0
    tick(1'b0, 8'd0, 3'd0, 1'b1, 7'h02);
    gated = 0;
    for (int i = 0; i < 8; i++) begin
      tick(1'b0, 8'd0, 3'd0, 1'b0, 7'd0);
      gated += int'(clk_gate);
    end
    check(gated == 0, 1'b1, "R7 duty zero gates none");

    // random phase, temperatures below trip
    tick(1'b0, 8'd0, 3'd0, 1'b1, 7'h0D);
    for (int i = 0; i < 3000; i++) begin
      rt  = ($urandom % 4 == 0) ? 8'($urandom % 124) : 8'(92 + $urandom % 14);
      rps = ($urandom % 3 == 0) ? 3'($urandom % 8) : 3'd0;
      if ($urandom % 40 == 0)
        tick($urandom % 2 == 1, rt, rps, 1'b1, 7'($urandom));
      else
        tick($urandom % 2 == 1, rt, rps, 1'b0, 7'd0);
    end

    // R5: trip while asleep with all modes off
    tick(1'b0, 8'd0, 3'd2, 1'b1, 7'h00);
    tick(1'b1, 8'd125, 3'd2, 1'b0, 7'd0);
    tick(1'b1, 8'd30, 3'd2, 1'b0, 7'd0);
    check(trip, 1'b1, "R5 trip at 125 asleep");
    hold(10, 8'd0, 3'd0);
    check(trip, 1'b1, "R5 trip stays latched");
    do_reset();
    check(trip, 1'b0, "R5 trip cleared by reset");
    hold(4, 8'd0, 3'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule